// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block decides when a small 8-bit processor core must take an interrupt. There are two sources: a USB event input and a timer/event-counter overflow pulse. The CPU sees one 8-bit control word that it can read and write. The word holds a master enable, an enable for each source and a pending flag for each source. When a pending source is enabled and the return stack has room, the block raises a call request and presents the program address of the service routine. The core's sequencer answers with an acknowledge.

Taking a service clears two bits: the master enable and the flag of the source that was serviced. Further interrupts therefore stay blocked until software turns the master enable back on. Software may do that inside a service routine to allow nesting. The flags keep recording events while interrupts are blocked. Any pending flag drives a wake-up output so that the core can leave a halted state. The word bus, the program-counter push and the stack itself live outside the block. Only a stack-full indication reaches it.

Top module: `irq_ctrl_unit`

## Requirements
- R1: After reset the control word reads 8'h00. Bits 2, 6 and 7 always read 0, so writing 8'hFF reads back as 8'h3B. A write takes effect on the next clock edge.
- R2: The control word has these bit positions: bit 0 is the master enable, bit 1 the USB enable, bit 3 the timer enable, bit 4 the USB flag and bit 5 the timer flag. A pulse on any bit of `usb_evt` sets bit 4 at the next edge. The four bits of `usb_evt` are endpoint FIFO access, suspend, resume and bus reset. A pulse on `tmr_evt` sets bit 5 at the next edge.
- R3: `irq_req` is high exactly when the master enable is set, `stk_full` is low, and at least one source has both its enable and its flag set.
- R4: An acknowledge taken while `irq_req` is high clears the master enable and the flag of the serviced source at the next edge. The other source's flag is left alone.
- R5: `irq_vec` is 11'h004 for the USB source and 11'h008 for the timer. When both are requestable, the USB source is chosen.
- R6: Events that arrive while the master enable is clear are still latched in their flags. They are requested once software sets the enable.
- R7: While `stk_full` is high, `irq_req` stays low and an acknowledge changes nothing.
- R8: `wake` is high whenever either flag is set, whatever the enables are.
- R9: Software that sets the master enable again inside a service routine gets a nested request for a still-pending enabled source.
- R10: An acknowledge while `irq_req` is low leaves the control word unchanged.
- R11: When an event pulse and a CPU write that clears the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | CPU write strobe for the control word |
| ctl_wdata | input | 8 | CPU write data |
| ctl_rdata | output | 8 | Current control word |
| usb_evt | input | 4 | USB event pulses: FIFO access, suspend, resume, bus reset |
| tmr_evt | input | 1 | Timer/event counter overflow pulse |
| stk_full | input | 1 | Return stack full |
| irq_ack | input | 1 | Sequencer has taken the call |
| irq_req | output | 1 | Vectored call request |
| irq_vec | output | 11 | Service routine address |
| wake | output | 1 | Leave-halt request |

## Verification
Writes, event pulses and acknowledges all change the control word at the first clock edge after the cycle in which they are applied. `irq_req`, `irq_vec` and `wake` are combinational from that word and from `stk_full`, so they move in the same cycle as the word. A change on `stk_full` reaches `irq_req` with no clock edge in between. The bench changes its inputs only at falling edges and lets a behavioural model step at each rising edge. It compares every output at the following falling edge, which is exactly one register stage after the stimulus. The directed checks sample at the same point.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int CTL_W    = 8;
   localparam int GEN_BIT  = 0;
   localparam int UEN_BIT  = 1;
   localparam int TEN_BIT  = 3;
   localparam int UFLG_BIT = 4;
   localparam int TFLG_BIT = 5;
   localparam logic [CTL_W-1:0] CTL_LIVE =
      (8'd1 << GEN_BIT) | (8'd1 << UEN_BIT) | (8'd1 << TEN_BIT) |
      (8'd1 << UFLG_BIT) | (8'd1 << TFLG_BIT);

   typedef enum logic {SRC_USB = 1'b0, SRC_TMR = 1'b1} irq_src_e;
endpackage

// File: rtl/irq_ctl_word.sv
module irq_ctl_word
   import irq_pkg::*;
#(
   parameter int N_USB_EV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CTL_W-1:0] wr_data,
   input  logic [N_USB_EV-1:0] usb_evt,
   input  logic             tmr_evt,
   input  logic             take,
   input  irq_src_e         take_src,
   output logic [CTL_W-1:0] ctl
);
   initial begin
      assert (N_USB_EV >= 1) else $error("N_USB_EV must be at least 1");
   end

   logic [CTL_W-1:0] ctl_nxt;
   logic             usb_any;

   assign usb_any = |usb_evt;

   always_comb begin
      ctl_nxt = ctl;
      if (wr_en) ctl_nxt = wr_data & CTL_LIVE;
      if (take) begin
         ctl_nxt[GEN_BIT] = 1'b0;
         if (take_src == SRC_USB) ctl_nxt[UFLG_BIT] = 1'b0;
         else                     ctl_nxt[TFLG_BIT] = 1'b0;
      end
      if (usb_any) ctl_nxt[UFLG_BIT] = 1'b1;
      if (tmr_evt) ctl_nxt[TFLG_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ctl <= '0;
      else        ctl <= ctl_nxt;
   end

   AST_USB_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      usb_any |=> ctl[UFLG_BIT]); // R2
   AST_TMR_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_evt |=> ctl[TFLG_BIT]); // R2
   AST_TAKE_DROPS_GEN: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !ctl[GEN_BIT]); // R4
   AST_TAKE_DROPS_UFLG: assert property (@(posedge clk) disable iff (!rst_n)
      (take && take_src == SRC_USB && !usb_any) |=> !ctl[UFLG_BIT]); // R4
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !take && !usb_any && !tmr_evt) |=> $stable(ctl)); // R10
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import irq_pkg::*;
#(
   parameter int          ADDR_W    = 11,
   parameter int unsigned USB_VEC   = 4,
   parameter int unsigned TMR_VEC   = 8,
   parameter bit          USB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gen,
   input  logic              usb_pend,
   input  logic              tmr_pend,
   input  logic              stk_full,
   output logic              req,
   output irq_src_e          src,
   output logic [ADDR_W-1:0] vec
);
   localparam logic [ADDR_W-1:0] USB_A = ADDR_W'(USB_VEC);
   localparam logic [ADDR_W-1:0] TMR_A = ADDR_W'(TMR_VEC);

   initial begin
      assert (ADDR_W >= 4 && ADDR_W <= 16) else $error("ADDR_W out of range");
      assert (USB_VEC < (1 << ADDR_W) && TMR_VEC < (1 << ADDR_W))
         else $error("vector does not fit ADDR_W");
      assert (USB_VEC != TMR_VEC) else $error("vectors must differ");
   end

   generate
      if (USB_FIRST) begin : g_usb_first
         assign src = usb_pend ? SRC_USB : SRC_TMR;
      end else begin : g_tmr_first
         assign src = tmr_pend ? SRC_TMR : SRC_USB;
      end
   endgenerate

   assign req = gen && !stk_full && (usb_pend || tmr_pend);
   assign vec = (src == SRC_USB) ? USB_A : TMR_A;

   AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      stk_full |-> !req); // R7
   AST_VEC_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      req |-> (vec == USB_A || vec == TMR_A)); // R5
   AST_NO_IDLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!usb_pend && !tmr_pend) |-> !req); // R3
endmodule

// File: rtl/irq_ctrl_unit.sv
module irq_ctrl_unit
   import irq_pkg::*;
#(
   parameter int          ADDR_W    = 11,
   parameter int          N_USB_EV  = 4,
   parameter int unsigned USB_VEC   = 4,
   parameter int unsigned TMR_VEC   = 8,
   parameter bit          USB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [7:0]        ctl_wdata,
   output logic [7:0]        ctl_rdata,
   input  logic [N_USB_EV-1:0] usb_evt,
   input  logic              tmr_evt,
   input  logic              stk_full,
   input  logic              irq_ack,
   output logic              irq_req,
   output logic [ADDR_W-1:0] irq_vec,
   output logic              wake
);
   logic [CTL_W-1:0] ctl;
   logic             take;
   logic             usb_pend;
   logic             tmr_pend;
   irq_src_e         sel;

   assign take     = irq_ack && irq_req;
   assign usb_pend = ctl[UEN_BIT] && ctl[UFLG_BIT];
   assign tmr_pend = ctl[TEN_BIT] && ctl[TFLG_BIT];

   irq_ctl_word #(.N_USB_EV(N_USB_EV)) u_word (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctl_wr),
      .wr_data  (ctl_wdata),
      .usb_evt  (usb_evt),
      .tmr_evt  (tmr_evt),
      .take     (take),
      .take_src (sel),
      .ctl      (ctl)
   );

   irq_arbiter #(
      .ADDR_W    (ADDR_W),
      .USB_VEC   (USB_VEC),
      .TMR_VEC   (TMR_VEC),
      .USB_FIRST (USB_FIRST)
   ) u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .gen      (ctl[GEN_BIT]),
      .usb_pend (usb_pend),
      .tmr_pend (tmr_pend),
      .stk_full (stk_full),
      .req      (irq_req),
      .src      (sel),
      .vec      (irq_vec)
   );

   assign ctl_rdata = ctl;
   assign wake      = ctl[UFLG_BIT] || ctl[TFLG_BIT];

   AST_FULL_ACK_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_full && irq_ack && !ctl_wr && !(|usb_evt) && !tmr_evt)
      |=> $stable(ctl_rdata)); // R7
   AST_WAKE_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_evt |=> wake); // R8
endmodule

// File: tb/irq_ctrl_unit_tb.sv
module irq_ctrl_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_wr = 1'b0;
   logic [7:0]  ctl_wdata = 8'h00;
   logic [7:0]  ctl_rdata;
   logic [3:0]  usb_evt = 4'h0;
   logic        tmr_evt = 1'b0;
   logic        stk_full = 1'b0;
   logic        irq_ack = 1'b0;
   logic        irq_req;
   logic [10:0] irq_vec;
   logic        wake;

   int vectors = 0;
   int misses  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   irq_ctrl_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .usb_evt(usb_evt), .tmr_evt(tmr_evt),
      .stk_full(stk_full), .irq_ack(irq_ack), .irq_req(irq_req),
      .irq_vec(irq_vec), .wake(wake)
   );

   // behavioural reference
   int m_gen = 0, m_uen = 0, m_ten = 0, m_uf = 0, m_tf = 0;

   function automatic int exp_req();
      return (m_gen != 0 && !stk_full &&
              ((m_uen != 0 && m_uf != 0) || (m_ten != 0 && m_tf != 0))) ? 1 : 0;
   endfunction
   function automatic int exp_vec();
      return (m_uen != 0 && m_uf != 0) ? 4 : 8;
   endfunction
   function automatic int exp_word();
      return m_gen + 2*m_uen + 8*m_ten + 16*m_uf + 32*m_tf;
   endfunction

   always @(posedge clk) begin
      int g, u, t, uf, tf;
      if (!rst_n) begin
         g = 0; u = 0; t = 0; uf = 0; tf = 0;
      end else begin
         g = m_gen; u = m_uen; t = m_ten; uf = m_uf; tf = m_tf;
         if (ctl_wr) begin
            g = ctl_wdata[0]; u = ctl_wdata[1]; t = ctl_wdata[3];
            uf = ctl_wdata[4]; tf = ctl_wdata[5];
         end
         if (irq_ack && exp_req() == 1) begin
            g = 0;
            if (exp_vec() == 4) uf = 0; else tf = 0;
         end
         if (usb_evt != 4'h0) uf = 1;
         if (tmr_evt) tf = 1;
      end
      m_gen <= g; m_uen <= u; m_ten <= t; m_uf <= uf; m_tf <= tf;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         misses++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic compare();
      check(int'(ctl_rdata) == exp_word(), "R1 word", ctl_rdata, exp_word());
      check(int'(irq_req) == exp_req(), "R3 req", irq_req, exp_req());
      if (exp_req() == 1)
         check(int'(irq_vec) == exp_vec(), "R5 vec", irq_vec, exp_vec());
      check(int'(wake) == ((m_uf | m_tf) != 0 ? 1 : 0), "R8 wake", wake, m_uf | m_tf);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      if (rst_n) compare();
      cycles++;
   endtask

   task automatic wr(input logic [7:0] d);
      ctl_wr = 1'b1; ctl_wdata = d;
      tick();
      ctl_wr = 1'b0;
   endtask

   task automatic ack();
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      misses++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
      finish_run();
   end

   initial begin
      @(negedge clk); @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ctl_rdata == 8'h00, "R1 reset", ctl_rdata, 8'h00);
      check(!irq_req && !wake, "R1 reset outputs", {irq_req, wake}, 0);

      // R1 unused bits
      wr(8'hFF);
      check(ctl_rdata == 8'h3B, "R1 masked write", ctl_rdata, 8'h3B);
      wr(8'h00);

      // R2 each USB event, R6 latched while disabled, R8 wake
      for (int i = 0; i < 4; i++) begin
         usb_evt = 4'(1 << i);
         tick();
         usb_evt = 4'h0;
         check(ctl_rdata[4], "R2 usb event", ctl_rdata[4], 1);
         check(wake, "R8 wake", wake, 1);
         check(!irq_req, "R6 no req while disabled", irq_req, 0);
         wr(8'h00);
      end

      // R6 timer latched with enable off, serviced later
      tmr_evt = 1'b1; tick(); tmr_evt = 1'b0;
      check(ctl_rdata == 8'h20, "R6 latched timer", ctl_rdata, 8'h20);
      wr(8'h29);
      check(irq_req && irq_vec == 11'h008, "R5 timer vec", irq_vec, 11'h008);
      ack();
      check(ctl_rdata == 8'h08, "R4 timer ack clears", ctl_rdata, 8'h08);
      check(!wake, "R8 wake low", wake, 0);

      // R5 priority, R7 stack full
      wr(8'h3B);
      check(irq_vec == 11'h004, "R5 usb priority", irq_vec, 11'h004);
      stk_full = 1'b1;
      tick();
      check(!irq_req, "R7 blocked", irq_req, 0);
      ack();
      check(ctl_rdata == 8'h3B, "R7 ack ignored when full", ctl_rdata, 8'h3B);
      stk_full = 1'b0;
      tick();
      check(irq_req, "R7 resumes", irq_req, 1);
      ack();
      check(ctl_rdata == 8'h2A, "R4 usb ack clears only usb", ctl_rdata, 8'h2A);

      // R9 nesting by re-enabling
      wr(8'h2B);
      check(irq_req && irq_vec == 11'h008, "R9 nested req", irq_vec, 11'h008);
      ack();
      check(ctl_rdata == 8'h0A, "R9 nested ack", ctl_rdata, 8'h0A);

      // R10 ack without request
      wr(8'h32);
      ack();
      check(ctl_rdata == 8'h32, "R10 idle ack", ctl_rdata, 8'h32);

      // R11 event beats clearing write
      ctl_wr = 1'b1; ctl_wdata = 8'h02; usb_evt = 4'h4;
      tick();
      ctl_wr = 1'b0; usb_evt = 4'h0;
      check(ctl_rdata == 8'h12, "R11 event wins", ctl_rdata, 8'h12);
      ctl_wr = 1'b1; ctl_wdata = 8'h01; tmr_evt = 1'b1;
      tick();
      ctl_wr = 1'b0; tmr_evt = 1'b0;
      check(ctl_rdata == 8'h21, "R11 timer event wins", ctl_rdata, 8'h21);

      // mixed traffic against the model (R3)
      for (int k = 0; k < 200; k++) begin
         ctl_wr    = (k % 7) == 0;
         ctl_wdata = 8'((k * 37) ^ 8'h5A);
         usb_evt   = ((k % 5) == 0) ? 4'(1 << (k % 4)) : 4'h0;
         tmr_evt   = (k % 9) == 3;
         stk_full  = (k % 11) < 2;
         irq_ack   = (k % 3) == 1;
         tick();
      end
      ctl_wr = 1'b0; usb_evt = 4'h0; tmr_evt = 1'b0; stk_full = 1'b0; irq_ack = 1'b0;
      tick();
      finish_run();
   end
endmodule